// File: doc/BRIEF.md
# Multifunction ALU with Staged Shifter

This block is the combinational arithmetic/logic unit of a small load/store integer datapath. It takes two operands, a shift amount and an 8-bit control word, and in the same cycle returns one result word with a zero flag and an overflow flag. Inside are four parts: a two's-complement adder/subtractor built on a generate/propagate carry chain, a four-function bitwise unit, a barrel shifter made of power-of-two stages, and a final multiplexer that picks one of four function classes.

The control word has four independent fields, one each for the function class, the add/subtract choice, the shift kind and the logic function. Set-less-than reuses the subtractor and corrects the sign of the difference for overflow, so it gives the true signed comparison. Right shifts can be logical or arithmetic. The shift distance comes either from a dedicated amount input or from the low bits of operand A.

Top module: `mf_alu`

## Requirements
- R1: The control word splits as follows. Bits [7:6] give the class (00 shift, 01 set-less-than, 10 arithmetic, 11 logic). Bit [5] selects subtract. Bits [4:2] give the shift kind. Bits [1:0] give the logic function.
- R2: In the arithmetic class, the result is A+B when bit 5 is 0 and A−B when bit 5 is 1, both modulo 2^WIDTH.
- R3: `ovf_o` is 1 only in the arithmetic class. It is set when the two values the adder sums have the same sign and the sum's sign differs from it. Adding operands of opposite sign never sets it.
- R4: In the set-less-than class, the result is 1 when A < B as signed numbers and 0 otherwise, and all upper bits are 0. Bit 5 has no effect in this class.
- R5: In the logic class, bits [1:0] select the function: 00 AND, 01 OR, 10 XOR, 11 NOR.
- R6: In the shift class, operand B is shifted. Shift-kind bits [1:0] select: 10 logical right, 11 arithmetic right (sign bit fills the vacated positions), 00 or 01 logical left.
- R7: Shift-kind bit [2] selects the distance: 0 uses `shamt_i`, 1 uses the low log2(WIDTH) bits of A. Higher bits of A do not affect the shift.
- R8: `zero_o` is 1 exactly when the result is all zeros, in every class.
- R9: A shift distance of 0 returns B unchanged for every shift kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | WIDTH | Operand A; its low bits also serve as the variable shift distance |
| opb_i | input | WIDTH | Operand B; the value that gets shifted |
| shamt_i | input | $clog2(WIDTH) | Constant shift distance |
| ctrl_i | input | 8 | Control word (class, subtract, shift kind, logic function) |
| result_o | output | WIDTH | Selected result |
| zero_o | output | 1 | Result is all zeros |
| ovf_o | output | 1 | Signed overflow of an arithmetic-class operation |

## Verification
The block holds no state, so any fault shows on the ports in the same evaluation as the input vector that excites it. A broken carry link corrupts the sum, and the set-less-than bit and the overflow flag with it, only for operand pairs whose carry runs through that position. A broken shifter stage affects only distances that have that stage's bit set, so the sweep crosses every distance with sign-set and sign-clear operands. Running every control word over a grid of operands plus the corner values catches a wrong field decode after the first vector of the affected class.

// File: rtl/mf_alu_pkg.sv
package mf_alu_pkg;
   typedef enum logic [1:0] {
      CLS_SHIFT = 2'b00,
      CLS_SLT   = 2'b01,
      CLS_ARITH = 2'b10,
      CLS_LOGIC = 2'b11
   } alu_class_e;

   typedef enum logic [1:0] {
      LOG_AND = 2'b00,
      LOG_OR  = 2'b01,
      LOG_XOR = 2'b10,
      LOG_NOR = 2'b11
   } alu_logic_e;

   localparam int CTRL_W     = 8;
   localparam int CLS_HI     = 7;
   localparam int CLS_LO     = 6;
   localparam int SUB_BIT    = 5;
   localparam int SH_VAR_BIT = 4;
   localparam int SH_DIR_BIT = 3;
   localparam int SH_ARI_BIT = 2;
   localparam int LOG_HI     = 1;
   localparam int LOG_LO     = 0;
endpackage

// File: rtl/mf_alu_adder.sv
module mf_alu_adder #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] x_i,
   input  logic [WIDTH-1:0] y_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             cout_o,
   output logic             ovf_o
);
   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0] gen, prop;
   logic [WIDTH:0]   carry;

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         assign gen[i]  = x_i[i] & y_i[i];
         assign prop[i] = x_i[i] ^ y_i[i];
      end
   endgenerate

   always_comb begin
      carry[0] = cin_i;
      for (int i = 0; i < WIDTH; i++) begin
         carry[i+1] = gen[i] | (prop[i] & carry[i]);
      end
   end

   assign sum_o  = prop ^ carry[WIDTH-1:0];
   assign cout_o = carry[WIDTH];
   assign ovf_o  = (x_i[MSB] == y_i[MSB]) & (sum_o[MSB] != x_i[MSB]);

   always_comb begin
      if (!$isunknown({x_i, y_i, cin_i})) begin
         p_sum_ref_r2 : assert ({cout_o, sum_o} ==
                                ({1'b0, x_i} + {1'b0, y_i} + {{WIDTH{1'b0}}, cin_i}))
            else $error("adder sum disagrees with arithmetic reference");
      end
   end
endmodule

// File: rtl/mf_alu_logic.sv
module mf_alu_logic #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic [1:0]       fn_i,
   output logic [WIDTH-1:0] y_o
);
   import mf_alu_pkg::*;

   always_comb begin
      unique case (alu_logic_e'(fn_i))
         LOG_AND: y_o = a_i & b_i;
         LOG_OR:  y_o = a_i | b_i;
         LOG_XOR: y_o = a_i ^ b_i;
         LOG_NOR: y_o = ~(a_i | b_i);
         default: y_o = '0;
      endcase
   end

   always_comb begin
      if (!$isunknown({a_i, b_i, fn_i}) && fn_i == LOG_XOR) begin
         p_xor_split_r5 : assert ((y_o & a_i & b_i) == '0 && (y_o | (a_i & b_i)) == (a_i | b_i))
            else $error("xor output not the exclusive part of the operands");
      end
   end
endmodule

// File: rtl/mf_alu_shifter.sv
module mf_alu_shifter #(
   parameter int WIDTH = 32,
   parameter int SHW   = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] din_i,
   input  logic [SHW-1:0]   amt_i,
   input  logic             right_i,
   input  logic             arith_i,
   output logic [WIDTH-1:0] dout_o
);
   localparam int MSB = WIDTH - 1;

   logic                      fill;
   logic [SHW:0][WIDTH-1:0]   stg;

   assign fill   = arith_i & right_i & din_i[MSB];
   assign stg[0] = din_i;

   generate
      for (genvar k = 0; k < SHW; k++) begin : g_stage
         localparam int S = 1 << k;
         assign stg[k+1] = !amt_i[k] ? stg[k] :
                           right_i  ? {{S{fill}}, stg[k][WIDTH-1:S]} :
                                      {stg[k][WIDTH-1-S:0], {S{1'b0}}};
      end
   endgenerate

   assign dout_o = stg[SHW];

   always_comb begin
      if (!$isunknown({din_i, amt_i, right_i, arith_i})) begin
         if (!right_i) begin
            p_shl_ref_r6 : assert (dout_o == (din_i << amt_i))
               else $error("left shift mismatch");
         end else if (arith_i) begin
            p_sra_ref_r6 : assert ($signed(dout_o) == ($signed(din_i) >>> amt_i))
               else $error("arithmetic right shift mismatch");
         end else begin
            p_srl_ref_r6 : assert (dout_o == (din_i >> amt_i))
               else $error("logical right shift mismatch");
         end
         if (amt_i == '0) begin
            p_pass_zero_r9 : assert (dout_o == din_i)
               else $error("zero distance altered the value");
         end
      end
   end
endmodule

// File: rtl/mf_alu.sv
module mf_alu #(
   parameter int WIDTH = 32,
   parameter int SHW   = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0]                opa_i,
   input  logic [WIDTH-1:0]                opb_i,
   input  logic [SHW-1:0]                  shamt_i,
   input  logic [mf_alu_pkg::CTRL_W-1:0]   ctrl_i,
   output logic [WIDTH-1:0]                result_o,
   output logic                            zero_o,
   output logic                            ovf_o
);
   import mf_alu_pkg::*;

   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 4 || (WIDTH & (WIDTH - 1)) != 0) begin : g_bad_width
         $error("mf_alu: WIDTH must be a power of two and at least 4");
      end
      if (SHW != $clog2(WIDTH)) begin : g_bad_shw
         $error("mf_alu: SHW must equal log2 of WIDTH");
      end
   endgenerate

   alu_class_e        cls;
   logic              do_sub;
   logic [WIDTH-1:0]  add_y, sum, logic_y, shift_y;
   logic              add_cout, add_ovf, slt_bit;
   logic [SHW-1:0]    sh_amt;

   assign cls    = alu_class_e'(ctrl_i[CLS_HI:CLS_LO]);
   assign do_sub = ctrl_i[SUB_BIT] | (cls == CLS_SLT);
   assign add_y  = do_sub ? ~opb_i : opb_i;

   mf_alu_adder #(.WIDTH(WIDTH)) u_add (
      .x_i    (opa_i),
      .y_i    (add_y),
      .cin_i  (do_sub),
      .sum_o  (sum),
      .cout_o (add_cout),
      .ovf_o  (add_ovf)
   );

   mf_alu_logic #(.WIDTH(WIDTH)) u_log (
      .a_i  (opa_i),
      .b_i  (opb_i),
      .fn_i (ctrl_i[LOG_HI:LOG_LO]),
      .y_o  (logic_y)
   );

   assign sh_amt = ctrl_i[SH_VAR_BIT] ? opa_i[SHW-1:0] : shamt_i;

   mf_alu_shifter #(.WIDTH(WIDTH), .SHW(SHW)) u_shf (
      .din_i   (opb_i),
      .amt_i   (sh_amt),
      .right_i (ctrl_i[SH_DIR_BIT]),
      .arith_i (ctrl_i[SH_ARI_BIT]),
      .dout_o  (shift_y)
   );

   assign slt_bit = sum[MSB] ^ add_ovf;

   always_comb begin
      unique case (cls)
         CLS_SHIFT: result_o = shift_y;
         CLS_SLT:   result_o = {{(WIDTH-1){1'b0}}, slt_bit};
         CLS_ARITH: result_o = sum;
         CLS_LOGIC: result_o = logic_y;
         default:   result_o = '0;
      endcase
   end

   assign zero_o = (result_o == '0);
   assign ovf_o  = (cls == CLS_ARITH) & add_ovf;

   always_comb begin
      if (!$isunknown({opa_i, opb_i, shamt_i, ctrl_i})) begin
         if (cls == CLS_ARITH && !ctrl_i[SUB_BIT] && opa_i[MSB] != opb_i[MSB]) begin
            p_no_overflow_r3 : assert (!ovf_o)
               else $error("overflow flagged on mixed-sign addition");
         end
         if (cls != CLS_ARITH) begin
            p_ovf_class_r3 : assert (!ovf_o)
               else $error("overflow flagged outside arithmetic class");
         end
         if (cls == CLS_SLT) begin
            p_slt_bit_r4 : assert (result_o[WIDTH-1:1] == '0)
               else $error("set-less-than upper bits not clear");
         end
         if (cls == CLS_LOGIC && ctrl_i[LOG_HI:LOG_LO] == LOG_OR) begin
            p_or_cover_r5 : assert ((result_o & opa_i) == opa_i && (result_o & opb_i) == opb_i)
               else $error("or result fails to cover an operand");
         end
      end
   end
endmodule

// File: tb/mf_alu_bench.sv
module mf_alu_bench;
   localparam int W   = 8;
   localparam int SHW = 3;
   localparam int MAXCYC = 150000;

   logic          clk = 1'b0;
   logic [W-1:0]  opa, opb;
   logic [SHW-1:0] shamt;
   logic [7:0]    ctrl;
   logic [W-1:0]  result;
   logic          zero, ovf;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc   = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;   // 250 MHz
   always @(posedge clk) cyc <= cyc + 1;

   mf_alu #(.WIDTH(W), .SHW(SHW)) u_mf_alu (
      .opa_i    (opa),
      .opb_i    (opb),
      .shamt_i  (shamt),
      .ctrl_i   (ctrl),
      .result_o (result),
      .zero_o   (zero),
      .ovf_o    (ovf)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s ctrl=%02h a=%02h b=%02h sh=%0d actual=%0h expected=%0h",
                  tag, ctrl, opa, opb, shamt, act, exp);
      end
   endtask

   // Apply one vector and compare against an arithmetic model.
   task automatic run(input int a, input int b, input int sa, input int c);
      int cls, amt, res, ov, sa_s, sb_s, sum;
      string tag;
      @(posedge clk);
      opa = W'(a); opb = W'(b); shamt = SHW'(sa); ctrl = 8'(c);
      @(negedge clk);
      cls  = (c >> 6) & 3;
      sa_s = (a >= 128) ? a - 256 : a;
      sb_s = (b >= 128) ? b - 256 : b;
      ov   = 0;
      case (cls)
         0: begin
            amt = ((c >> 4) & 1) ? (a & 7) : sa;
            if (((c >> 3) & 1) == 0) res = (b << amt) & 255;
            else if ((c >> 2) & 1)   res = (sb_s >>> amt) & 255;
            else                     res = b >> amt;
            tag = (amt == 0) ? "R9" : (((c >> 4) & 1) ? "R7" : "R6");
         end
         1: begin res = (sa_s < sb_s) ? 1 : 0; tag = "R4"; end
         2: begin
            sum = ((c >> 5) & 1) ? sa_s - sb_s : sa_s + sb_s;
            res = sum & 255;
            ov  = (sum > 127 || sum < -128) ? 1 : 0;
            tag = "R2";
         end
         default: begin
            case (c & 3)
               0: res = a & b;
               1: res = a | b;
               2: res = a ^ b;
               default: res = (~(a | b)) & 255;
            endcase
            tag = "R5";
         end
      endcase
      check(tag, int'(result), res);
      check("R8", int'(zero), (res == 0) ? 1 : 0);
      check("R3", int'(ovf), ov);
   endtask

   initial begin
      int corner [5] = '{0, 1, 127, 128, 255};
      opa = '0; opb = '0; shamt = '0; ctrl = '0;
      // R1: all-zero control word is a left shift by zero of zero
      @(negedge clk);
      check("R1", int'(result), 0);
      check("R8", int'(zero), 1);
      check("R3", int'(ovf), 0);
      // R1 R2 R4 R5 R6 R7: every control word over corner operands
      for (int c = 0; c < 256; c++)
         for (int i = 0; i < 5; i++)
            for (int j = 0; j < 5; j++)
               run(corner[i], corner[j], (i + j) % 8, c);
      // every control word over an operand grid; distances cycle through all values
      for (int c = 0; c < 256; c++)
         for (int a = 0; a < 256; a += 17)
            for (int b = 3; b < 256; b += 13)
               run(a, b, (a + b + c) % 8, c);
      // R7: high bits of A must not affect a variable shift
      run(8'hF9, 8'hA5, 0, 8'b00_0_111_00);
      run(8'h01, 8'hA5, 0, 8'b00_0_111_00);
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      wait (cyc >= MAXCYC);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected<%0d cycles", cyc, MAXCYC);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule